// File: doc/BRIEF.md
# Tiled View Address Generator

This block turns a pixel coordinate into a byte address inside a tiled two-dimensional memory container. A request carries a pixel format code, an orientation code and X/Y coordinates. The block checks the coordinates against the field widths of that format and applies the requested mirroring and transposition. It packs the two coordinates into one container index, shifts the index by the format's alignment, and tags the result with the orientation and format codes. Alongside the address it reports the line stride of the format and an out-of-range flag.

Requests enter through a valid/ready handshake and the result leaves through a second one, one clock after acceptance. A two-state controller holds the output register. In `ST_EMPTY` no result is pending. In `ST_FULL` a result is presented until it is taken. The transitions are: `T_LOAD` (`ST_EMPTY` to `ST_FULL` on an accepted request), `T_STREAM` (`ST_FULL` stays full when the result is taken and a new request is accepted in the same cycle), `T_STALL` (`ST_FULL` stays full and holds its contents while the consumer is not ready) and `T_DRAIN` (`ST_FULL` to `ST_EMPTY` when the result is taken and no request arrives). Page mode skips tiling and passes a linear offset through.

Top module: `tvg_addr_gen`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: Format codes are 0 = 8-bit, 1 = 16-bit, 2 = 32-bit and 3 = page. For the tiled formats, the (X shift, Y shift) pairs are 8-bit (0,0), 16-bit (0,1) and 32-bit (1,1). The X field width is 14 minus the X shift and the Y field width is 13 minus the Y shift. Without transpose the index is (Y << X width) + X. The index is shifted left by X shift + Y shift and placed in bits [26:0].
- R3: Orientation bit 2 selects transpose. The index then becomes (X << Y width) + Y, and the alignment shift still applies.
- R4: Orientation bit 0 XORs X with its all-ones field mask, and orientation bit 1 does the same to Y with its mask. Both are applied before packing.
- R5: For a tiled format, an X or Y above its field mask gives `out_err` = 1 and `out_addr` = 0. The result is still delivered through the output handshake.
- R6: In page mode the address bits [26:0] are {Y, X}, with no mirroring, no transpose and no range error. The orientation tag is forced to 0.
- R7: The orientation code sits in `out_addr[31:29]` and the format code in `out_addr[28:27]`. A request accepted on one clock edge gives `out_valid` = 1 after that edge, with its result.
- R8: `out_stride` is 2^(14 + Y shift) for the tiled formats and 2^14 for page mode.
- R9: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0, and `out_addr`, `out_err` and `out_stride` stay unchanged.
- R10: When `out_ready` is 1, a new request is accepted every cycle and the results follow back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted when high with in_valid |
| in_fmt | input | 2 | Pixel format code |
| in_orient | input | 3 | Orientation code: bit0 X mirror, bit1 Y mirror, bit2 transpose |
| in_x | input | 14 | X coordinate |
| in_y | input | 13 | Y coordinate |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_addr | output | 32 | Tagged container address, 0 on a range error |
| out_err | output | 1 | Coordinate out of range |
| out_stride | output | 32 | Line stride of the request's format |

## Verification
The hardest situation to reach is a stall in which the consumer holds off while a new request already waits at the input. In that case the held result must not move and the waiting request must not be taken. The stimulus drops `out_ready` and presents a second request at once, then checks across two stalled cycles that the first address is unchanged and `in_ready` stays low. It then raises `out_ready` and confirms that the waiting request arrives exactly one cycle later. The range limits are checked at the exact edges of each format, where the masks shrink per format (Y limit 4095 in 16-bit, X limit 8191 in 32-bit).

// File: rtl/tvg_pkg.sv
package tvg_pkg;

    typedef enum logic [1:0] {
        FMT_B8  = 2'd0,
        FMT_B16 = 2'd1,
        FMT_B32 = 2'd2,
        FMT_LIN = 2'd3
    } fmt_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } ctrl_state_e;

    typedef struct packed {
        logic [1:0] xs;
        logic [1:0] ys;
    } geom_t;

endpackage

// File: rtl/tvg_geom.sv
module tvg_geom
    import tvg_pkg::*;
#(
    parameter int CW_BITS = 14,
    parameter int ADDR_W  = 32
) (
    input  logic [1:0]        fmt,
    output geom_t             geom,
    output logic [ADDR_W-1:0] stride
);

    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    always_comb begin
        geom = '0;
        unique case (fmt_e'(fmt))
            FMT_B8:  geom = '{xs: 2'd0, ys: 2'd0};
            FMT_B16: geom = '{xs: 2'd0, ys: 2'd1};
            FMT_B32: geom = '{xs: 2'd1, ys: 2'd1};
            FMT_LIN: geom = '{xs: 2'd0, ys: 2'd0};
            default: geom = '0;
        endcase
    end

    always_comb begin
        if (fmt_e'(fmt) == FMT_LIN) begin
            stride = ONE << CW_BITS;
        end else begin
            stride = ONE << (CW_BITS + int'(geom.ys));
        end
    end

endmodule

// File: rtl/tvg_pack.sv
module tvg_pack
    import tvg_pkg::*;
#(
    parameter int CW_BITS = 14,
    parameter int CH_BITS = 13,
    parameter int ADDR_W  = 32
) (
    input  logic [1:0]         fmt,
    input  logic [2:0]         orient,
    input  logic [CW_BITS-1:0] x,
    input  logic [CH_BITS-1:0] y,
    input  geom_t              geom,
    output logic [ADDR_W-1:0]  addr,
    output logic               err
);

    localparam int IDX_W = CW_BITS + CH_BITS;

    logic [CW_BITS-1:0] xmask, xm;
    logic [CH_BITS-1:0] ymask, ym;
    logic [5:0]         xw, yw;
    logic [2:0]         align;
    logic [IDX_W-1:0]   idx_tile, idx_shift, idx_lin;
    logic               is_lin, over;

    assign is_lin = (fmt_e'(fmt) == FMT_LIN);
    assign xmask  = {CW_BITS{1'b1}} >> geom.xs;
    assign ymask  = {CH_BITS{1'b1}} >> geom.ys;
    assign xw     = 6'(CW_BITS) - {4'd0, geom.xs};
    assign yw     = 6'(CH_BITS) - {4'd0, geom.ys};
    assign align  = {1'b0, geom.xs} + {1'b0, geom.ys};
    assign over   = ((x & ~xmask) != '0) || ((y & ~ymask) != '0);

    assign xm = orient[0] ? (x ^ xmask) : x;
    assign ym = orient[1] ? (y ^ ymask) : y;

    always_comb begin
        if (orient[2]) begin
            idx_tile = (IDX_W'(xm) << yw) + IDX_W'(ym);
        end else begin
            idx_tile = (IDX_W'(ym) << xw) + IDX_W'(xm);
        end
        idx_shift = idx_tile << align;
        idx_lin   = {y, x};
    end

    always_comb begin
        err  = 1'b0;
        addr = '0;
        if (is_lin) begin
            addr = ADDR_W'({3'b000, fmt, idx_lin});
        end else if (over) begin
            err  = 1'b1;
            addr = '0;
        end else begin
            addr = ADDR_W'({orient, fmt, idx_shift});
        end
    end

endmodule

// File: rtl/tvg_ctrl.sv
module tvg_ctrl
    import tvg_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ADDR_W-1:0] d_addr,
    input  logic              d_err,
    input  logic [ADDR_W-1:0] d_stride,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] out_addr,
    output logic              out_err,
    output logic [ADDR_W-1:0] out_stride
);

    ctrl_state_e state_q, state_d;
    logic        load;

    assign in_ready = (state_q == ST_EMPTY) || out_ready;
    assign load     = in_valid && in_ready;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (in_valid) state_d = ST_FULL;
            ST_FULL: begin
                if (out_ready && !in_valid) state_d = ST_EMPTY;
                else                        state_d = ST_FULL;
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_addr   <= '0;
            out_err    <= 1'b0;
            out_stride <= '0;
        end else if (load) begin
            out_addr   <= d_addr;
            out_err    <= d_err;
            out_stride <= d_stride;
        end
    end

    assign out_valid = (state_q == ST_FULL);

endmodule

// File: rtl/tvg_addr_gen.sv
module tvg_addr_gen
    import tvg_pkg::*;
#(
    parameter int CW_BITS = 14,
    parameter int CH_BITS = 13,
    parameter int ADDR_W  = CW_BITS + CH_BITS + 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [1:0]         in_fmt,
    input  logic [2:0]         in_orient,
    input  logic [CW_BITS-1:0] in_x,
    input  logic [CH_BITS-1:0] in_y,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [ADDR_W-1:0]  out_addr,
    output logic               out_err,
    output logic [ADDR_W-1:0]  out_stride
);

    geom_t             geom;
    logic [ADDR_W-1:0] c_addr, c_stride;
    logic              c_err;

    tvg_geom #(.CW_BITS(CW_BITS), .ADDR_W(ADDR_W)) u_geom (
        .fmt    (in_fmt),
        .geom   (geom),
        .stride (c_stride)
    );

    tvg_pack #(.CW_BITS(CW_BITS), .CH_BITS(CH_BITS), .ADDR_W(ADDR_W)) u_pack (
        .fmt    (in_fmt),
        .orient (in_orient),
        .x      (in_x),
        .y      (in_y),
        .geom   (geom),
        .addr   (c_addr),
        .err    (c_err)
    );

    tvg_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .d_addr     (c_addr),
        .d_err      (c_err),
        .d_stride   (c_stride),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_addr   (out_addr),
        .out_err    (out_err),
        .out_stride (out_stride)
    );

endmodule

// File: rtl/tvg_addr_gen_chk.sv
module tvg_addr_gen_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [ADDR_W-1:0] out_addr,
    input logic              out_err,
    input logic [ADDR_W-1:0] out_stride
);

    p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_err) && $stable(out_stride)));

    p_stall_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    p_accept_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    p_err_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_err) |-> (out_addr == '0));

    p_page_tag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_err && out_addr[ADDR_W-4:ADDR_W-5] == 2'd3) |-> (out_addr[ADDR_W-1:ADDR_W-3] == 3'd0));

    p_stream_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_ready |-> in_ready);

endmodule

bind tvg_addr_gen tvg_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_addr   (out_addr),
    .out_err    (out_err),
    .out_stride (out_stride)
);

// File: tb/tvg_addr_gen_tb.sv
module tvg_addr_gen_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [1:0]  in_fmt = '0;
    logic [2:0]  in_orient = '0;
    logic [13:0] in_x = '0;
    logic [12:0] in_y = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_addr;
    logic        out_err;
    logic [31:0] out_stride;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    tvg_addr_gen u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_fmt(in_fmt), .in_orient(in_orient), .in_x(in_x), .in_y(in_y),
        .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
        .out_err(out_err), .out_stride(out_stride)
    );

    // {fmt, orient, x, y, addr, err, stride}
    localparam int NV = 12;
    localparam logic [96:0] VEC [NV] = '{
        {2'd0, 3'd0, 14'd5,      13'd3,      32'h0000C005, 1'b0, 32'h00004000}, // R2 8-bit
        {2'd1, 3'd0, 14'd5,      13'd3,      32'h0801800A, 1'b0, 32'h00008000}, // R2 16-bit
        {2'd2, 3'd0, 14'd5,      13'd3,      32'h10018014, 1'b0, 32'h00008000}, // R2 32-bit
        {2'd0, 3'd1, 14'd0,      13'd0,      32'h20003FFF, 1'b0, 32'h00004000}, // R4 X mirror
        {2'd0, 3'd2, 14'd0,      13'd0,      32'h47FFC000, 1'b0, 32'h00004000}, // R4 Y mirror
        {2'd0, 3'd4, 14'd5,      13'd3,      32'h8000A003, 1'b0, 32'h00004000}, // R3 transpose
        {2'd2, 3'd4, 14'd5,      13'd3,      32'h9001400C, 1'b0, 32'h00008000}, // R3 transpose 32-bit
        {2'd1, 3'd0, 14'd0,      13'h1000,   32'h00000000, 1'b1, 32'h00008000}, // R5 Y over
        {2'd2, 3'd0, 14'h2000,   13'd0,      32'h00000000, 1'b1, 32'h00008000}, // R5 X over
        {2'd0, 3'd0, 14'h3FFF,   13'h1FFF,   32'h07FFFFFF, 1'b0, 32'h00004000}, // R5 edge in range
        {2'd3, 3'd7, 14'd5,      13'd3,      32'h1800C005, 1'b0, 32'h00004000}, // R6 page
        {2'd1, 3'd3, 14'd1,      13'd1,      32'h6FFF7FFC, 1'b0, 32'h00008000}  // R4 both mirrors 16-bit
    };

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [96:0] v);
        in_fmt    = v[96:95];
        in_orient = v[94:92];
        in_x      = v[91:78];
        in_y      = v[77:65];
    endtask

    task automatic check_out(input logic [96:0] v, input string tag);
        check(out_valid == 1'b1, {tag, " valid"}, 64'(out_valid), 64'd1);
        check(out_addr == v[64:33], {tag, " addr"}, 64'(out_addr), 64'(v[64:33]));
        check(out_err == v[32], {tag, " err"}, 64'(out_err), 64'(v[32]));
        check(out_stride == v[31:0], {tag, " R8 stride"}, 64'(out_stride), 64'(v[31:0]));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(out_valid == 1'b0, "R1 out_valid", 64'(out_valid), 64'd0);
        check(in_ready == 1'b1, "R1 in_ready", 64'(in_ready), 64'd1);
        rst_n = 1'b1;
        @(negedge clk);

        // R7 table walk: accept on one edge, result after it
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i]);
            in_valid = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
            check_out(VEC[i], $sformatf("R7 vec%0d", i));
            @(negedge clk);
            check(out_valid == 1'b0, "R7 drain", 64'(out_valid), 64'd0);
        end

        // R10 back-to-back streaming
        drive(VEC[0]);
        in_valid = 1'b1;
        @(negedge clk);
        check_out(VEC[0], "R10 stream0");
        drive(VEC[5]);
        @(negedge clk);
        check_out(VEC[5], "R10 stream1");
        drive(VEC[10]);
        @(negedge clk);
        in_valid = 1'b0;
        check_out(VEC[10], "R10 stream2");
        @(negedge clk);

        // R9 stall with a waiting request
        drive(VEC[2]);
        in_valid  = 1'b1;
        out_ready = 1'b0;
        @(negedge clk);
        check_out(VEC[2], "R9 stall first");
        drive(VEC[3]);
        check(in_ready == 1'b0, "R9 in_ready low", 64'(in_ready), 64'd0);
        @(negedge clk);
        check_out(VEC[2], "R9 held");
        check(in_ready == 1'b0, "R9 in_ready still low", 64'(in_ready), 64'd0);
        @(negedge clk);
        check_out(VEC[2], "R9 held2");
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check_out(VEC[3], "R9 released");
        @(negedge clk);
        check(out_valid == 1'b0, "R9 drained", 64'(out_valid), 64'd0);

        // R5 out-of-range result held under stall
        drive(VEC[8]);
        in_valid  = 1'b1;
        out_ready = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check_out(VEC[8], "R5 err under stall");
        out_ready = 1'b1;
        @(negedge clk);

        // R1 reset mid-stream clears the pending result
        drive(VEC[1]);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        #1;
        check(out_valid == 1'b0, "R1 async reset", 64'(out_valid), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule